// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits behind an APB slave interface. Each pin has a direction bit and an output data bit. The port drives an output-enable bus and an output-value bus to the pads. It brings the pad input bus in through a two-stage synchroniser.

The data register is reached through a window of 256 words. The word address inside that window is a per-pin mask, for reads and for writes alike. Software can therefore set, clear or sample any subset of pins in a single access, with no read-modify-write and no risk of disturbing pins it did not name. The direction register sits just above the window and is a plain read/write register. Every other offset is silent.

A small phase tracker follows the APB transfer. Its states are `PH_IDLE` (no select), `PH_SETUP` (select without enable) and `PH_ACCESS` (select with enable). Its transitions are:
- `PH_IDLE`→`PH_SETUP` and `PH_ACCESS`→`PH_SETUP` when a new transfer starts.
- `PH_SETUP`→`PH_ACCESS` when enable rises.
- `PH_SETUP` stays in `PH_SETUP` while enable is held low.
- Any state goes to `PH_IDLE` when select drops.

Register commits happen only in the access phase of a write.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, all direction bits are 0 (all pins inputs), the output data register is 0, `pad_oe` is 0 and `pad_out` is 0.
- R2: A write at byte offset 0x000–0x3FC updates output bit n from PWDATA[n] only when PADDR[2+n] is 1; the other output bits keep their value.
- R3: A read at byte offset 0x000–0x3FC returns 0 in bit n whenever PADDR[2+n] is 0.
- R4: For an unmasked pin, a data read returns the output register bit if the pin's direction bit is 1, and the synchronised pad input if it is 0.
- R5: The direction register at byte offset 0x400 is read/write, and a read returns its stored value. Direction bit n = 1 makes pin n an output, and `pad_oe[n]` follows it.
- R6: A change on `pad_in` becomes visible to data reads after exactly two rising clock edges, and not after one.
- R7: Offsets 0x404–0xFFC read as 0, and writes to them change neither register.
- R8: PRDATA[31:8] is always 0, PWDATA[31:8] is ignored, PREADY is always 1 and PSLVERR is always 0.
- R9: A register changes only on a cycle with PSEL, PENABLE and PWRITE all high. A setup-phase cycle with PWRITE high changes nothing.
- R10: `pad_out` always shows the output data register, whatever the direction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data; only bits 7:0 are used |
| prdata | output | 32 | APB read data, valid while selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Output enables to the pads (1 = drive) |

## Verification
The hardest situation to reach from the ports is the exact edge at which a pad change crosses the synchroniser. A normal APB read takes two cycles, which blurs the one-edge boundary. The bench therefore holds a data read in its setup phase, with select high and enable low, because read data is driven combinationally whenever the port is selected. It changes the pad bus at a falling edge and samples the read bus after the first and after the second rising edge. The masked-write corner cases are reached by walking a vector table that mixes partial masks, mixed directions and undecoded offsets. In that table, each write's effect is visible only through a later masked read.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    localparam int NPINS   = 8;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = ADDR_W - 2;
    // word index of the direction register, one above the masked window
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << NPINS);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_apb_phase.sv
module gpio_apb_phase
    import gpio_mask_pkg::*;
(
    input  logic pclk,
    input  logic presetn,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_en,
    output logic rd_sel
);
    apb_phase_e state_q, state_d;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state_q <= PH_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable) state_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (!psel)        state_d = PH_IDLE;
                else if (penable) state_d = PH_ACCESS;
            end
            PH_ACCESS: begin
                if (!psel)         state_d = PH_IDLE;
                else if (!penable) state_d = PH_SETUP;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        wr_en  = psel && penable && pwrite;
        rd_sel = psel && !pwrite;
    end

    // an access phase must follow a setup phase
    AST_ACCESS_AFTER_SETUP: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable) |-> (state_q == PH_SETUP)); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge pclk or negedge presetn) begin
                    if (!presetn) stage_q[s] <= '0;
                    else          stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge pclk or negedge presetn) begin
                    if (!presetn) stage_q[s] <= '0;
                    else          stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         pclk,
    input  logic         presetn,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dout_q
);
    logic wr_data, wr_dir;

    always_comb begin
        wr_data = wr_en && (sel == SEL_DATA);
        wr_dir  = wr_en && (sel == SEL_DIR);
    end

    generate
        for (genvar n = 0; n < W; n++) begin : g_pin
            always_ff @(posedge pclk or negedge presetn) begin
                if (!presetn)                 dout_q[n] <= 1'b0;
                else if (wr_data && mask[n])  dout_q[n] <= wdata[n];
            end
        end
    endgenerate

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)    dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    AST_MASKED_KEEP: assert property (@(posedge pclk) disable iff (!presetn)
        wr_data |=> (((dout_q ^ $past(dout_q)) & ~$past(mask)) == '0)); // R2
    AST_DATA_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_data |=> $stable(dout_q)); // R9
    AST_DIR_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_dir |=> $stable(dir_q)); // R7
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
(
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    logic              wr_en, rd_sel;
    logic [NPINS-1:0]  dir_q, dout_q, sync_in, mask;
    logic [WORD_W-1:0] word;
    reg_sel_e          sel;
    logic [NPINS-1:0]  rd_val;

    gpio_apb_phase u_phase (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_en   (wr_en),
        .rd_sel  (rd_sel)
    );

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
        .pclk    (pclk),
        .presetn (presetn),
        .d_in    (pad_in),
        .q_out   (sync_in)
    );

    always_comb begin
        word = paddr[ADDR_W-1:2];
        mask = paddr[NPINS+1:2];
        if (word < DIR_WORD)       sel = SEL_DATA;
        else if (word == DIR_WORD) sel = SEL_DIR;
        else                       sel = SEL_NONE;
    end

    gpio_port_regs #(.W(NPINS)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .wr_en   (wr_en),
        .sel     (sel),
        .mask    (mask),
        .wdata   (pwdata[NPINS-1:0]),
        .dir_q   (dir_q),
        .dout_q  (dout_q)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_val = ((dir_q & dout_q) | (~dir_q & sync_in)) & mask;
            SEL_DIR:  rd_val = dir_q;
            default:  rd_val = '0;
        endcase
        prdata = '0;
        if (rd_sel) prdata[NPINS-1:0] = rd_val;
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    AST_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        prdata[DATA_W-1:NPINS] == '0); // R8
    AST_MASKED_READ: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && (sel == SEL_DATA)) |-> ((prdata[NPINS-1:0] & ~mask) == '0)); // R3
    AST_UNDECODED_READ: assert property (@(posedge pclk) disable iff (!presetn)
        (sel == SEL_NONE) |-> (prdata == '0)); // R7
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 pclk = ~pclk;

    gpio_mask_port dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    // {write, byte address, write data, expected read}; pad_in held at A5
    localparam int NV = 18;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 12'h400, 8'h0F, 8'h00},  // R5 pins 0-3 outputs
        {1'b0, 12'h400, 8'h00, 8'h0F},  // R5 read back
        {1'b1, 12'h3FC, 8'h3C, 8'h00},  // R2 full mask
        {1'b0, 12'h3FC, 8'h00, 8'hAC},  // R4 mixed sources
        {1'b1, 12'h004, 8'h01, 8'h00},  // R2 single pin 0
        {1'b0, 12'h3FC, 8'h00, 8'hAD},  // R2 R4
        {1'b0, 12'h00C, 8'h00, 8'h01},  // R3 mask 03
        {1'b1, 12'h3C0, 8'h00, 8'h00},  // R2 clear pins 4-7 only
        {1'b0, 12'h3FC, 8'h00, 8'hAD},  // R4 inputs still from pads
        {1'b1, 12'h400, 8'hFF, 8'h00},  // R5 all outputs
        {1'b0, 12'h3FC, 8'h00, 8'h0D},  // R2 pins 4-7 were cleared
        {1'b1, 12'h404, 8'hFF, 8'h00},  // R7 undecoded write
        {1'b0, 12'h404, 8'h00, 8'h00},  // R7 undecoded read
        {1'b0, 12'h400, 8'h00, 8'hFF},  // R7 direction untouched
        {1'b1, 12'h800, 8'h00, 8'h00},  // R7 undecoded write
        {1'b0, 12'h3FC, 8'h00, 8'h0D},  // R7 data untouched
        {1'b1, 12'h000, 8'hFF, 8'h00},  // R2 empty mask
        {1'b0, 12'h3FC, 8'h00, 8'h0D}   // R2 nothing changed
    };

    initial begin
        logic [31:0] rd;
        // R1 reset state
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        check("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {24'h0, pad_out}, 32'h0);
        apb_read(12'h400, rd);
        check("R1 dir", rd, 32'h0);
        apb_read(12'h3FC, rd);
        check("R1 data", rd, 32'h0);
        check("R8 pready", {31'h0, pready}, 32'h1);
        check("R8 pslverr", {31'h0, pslverr}, 32'h0);

        pad_in = 8'hA5;
        repeat (3) @(negedge pclk);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) apb_write(VEC[i][27:16], {24'h0, VEC[i][15:8]});
            else begin
                apb_read(VEC[i][27:16], rd);
                check($sformatf("R2-vector %0d", i), rd, {24'h0, VEC[i][7:0]});
            end
        end

        // R10 pads show registers
        check("R10 pad_out", {24'h0, pad_out}, 32'h0D);
        check("R5 pad_oe", {24'h0, pad_oe}, 32'hFF);

        // R8 upper write data ignored
        apb_write(12'h400, 32'hFFFF_FF00);
        apb_read(12'h400, rd);
        check("R8 upper pwdata", rd, 32'h0);
        check("R10 pad_out inputs", {24'h0, pad_out}, 32'h0D);

        // R6 synchroniser latency; hold a read in setup phase
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = 12'h3FC;
        #1 check("R6 before", prdata, 32'hA5);
        pad_in = 8'h3C;
        @(negedge pclk);
        check("R6 one edge", prdata, 32'hA5);
        @(negedge pclk);
        check("R6 two edges", prdata, 32'h3C);
        psel = 0;

        // R9 setup-phase write without enable
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h3FC; pwdata = 32'hF0;
        @(negedge pclk);
        psel = 0; pwrite = 0;
        check("R9 pad_out", {24'h0, pad_out}, 32'h0D);
        apb_write(12'h400, 32'hFF);
        apb_read(12'h3FC, rd);
        check("R9 data", rd, 32'h0D);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge pclk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule